// File: doc/BRIEF.md
# Ping-Pong Self-Test Sequencer for Two Logic-Block Observer Registers

This block runs the self-test of two combinational networks placed in a ring between two multi-mode test registers, called register A and register B. Register A feeds network one, which feeds register B. Register B feeds network two, which feeds register A. The sequencer drives the two-bit mode of each register and their serial scan inputs. It samples their serial scan outputs, counts test cycles and compares the two captured signatures against expected words. The registers and networks stay outside the block.

The test runs in a ping-pong order. Register A first acts as the pattern source while register B compresses the responses of network one. The roles are then swapped. Register B's signature leaves through its scan chain while its seed for the second half goes in through the same chain in the same cycles. Register A is then cleared and compresses the responses of network two. A final unload brings register A's signature out. At that point the block raises done, together with a sticky fail flag that reflects both comparisons.

A test starts with a one-cycle start pulse while the block is idle or finished. The run length and both expected signatures are captured on that pulse.

Top module: `bist_pingpong_seq`

## Requirements
- R1: During reset and afterwards until a start is accepted, both mode outputs are 11 (normal), done and fail are 0, and both scan inputs are 0.
- R2: For the first W cycles after an accepted start, register A is in mode 00 (shift) and register B in mode 01 (clear). scan_in_a carries SEED_A with the most significant bit first.
- R3: The next N cycles run both registers in mode 10 (signature), where N is the captured run count and a count of 0 behaves as 1.
- R4: The next W cycles put register B in mode 00 and register A in mode 01. scan_in_b carries SEED_B with the most significant bit first, and scan_out_b is sampled every cycle. The first sampled bit is the most significant bit of the signature.
- R5: The next N cycles again run both registers in mode 10.
- R6: The next W cycles put register A in mode 00 and register B in mode 11, with scan_in_a at 0, while scan_out_a is sampled with the most significant bit first.
- R7: The word sampled from register B is compared with exp_sig_a, and fail shows the result in the first cycle of the second run. The word sampled from register A is compared with exp_sig_b, and fail shows that result together with done. Fail stays set once set and is cleared only by an accepted start.
- R8: After the unload, done is 1 and both modes are 11 until the next accepted start. That start clears done.
- R9: A start pulse that arrives while a test is in progress has no effect on the schedule or on the result.
- R10: Changing run_cycles, exp_sig_a or exp_sig_b after a start has been accepted has no effect on the running test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only when not running |
| run_cycles_i | input | CNT_W | Number of signature cycles per half (0 treated as 1) |
| exp_sig_a_i | input | W | Expected signature of network one (read from register B) |
| exp_sig_b_i | input | W | Expected signature of network two (read from register A) |
| scan_out_a_i | input | 1 | Serial output of register A (its MSB) |
| scan_out_b_i | input | 1 | Serial output of register B (its MSB) |
| scan_in_a_o | output | 1 | Serial input to register A |
| scan_in_b_o | output | 1 | Serial input to register B |
| mode_a_o | output | 2 | Mode of register A: 11 normal, 00 shift, 10 signature, 01 clear |
| mode_b_o | output | 2 | Mode of register B, same encoding |
| done_o | output | 1 | Test finished |
| fail_o | output | 1 | Sticky signature mismatch |

## Verification
Behavioural register and network models run in the bench, and the golden signatures come from an independent closed-form run of the same ring. Runs with both signatures correct show that the seeds, the bit order and the capture timing line up. A wrong first expected word and a wrong second expected word are each tried on their own, which separates the two compare points and shows that fail is sticky into done. A run count of zero shows the one-cycle floor. Start pulses and input changes injected mid-run show that the running test keeps its captured parameters. A restart after a failing run shows that fail and done are cleared.

// File: rtl/bist_seq_pkg.sv
package bist_seq_pkg;

    typedef enum logic [1:0] {
        MD_SHIFT = 2'b00,
        MD_CLEAR = 2'b01,
        MD_SIG   = 2'b10,
        MD_NORM  = 2'b11
    } reg_mode_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LOAD_A,
        PH_RUN_A,
        PH_SWAP,
        PH_RUN_B,
        PH_DRAIN,
        PH_DONE
    } phase_e;

    typedef struct packed {
        reg_mode_e a;
        reg_mode_e b;
    } mode_pair_t;

    function automatic logic is_scan(phase_e ph);
        return (ph == PH_LOAD_A) || (ph == PH_SWAP) || (ph == PH_DRAIN);
    endfunction

    function automatic logic is_busy(phase_e ph);
        return (ph != PH_IDLE) && (ph != PH_DONE);
    endfunction

    function automatic phase_e next_phase(phase_e ph);
        case (ph)
            PH_LOAD_A: return PH_RUN_A;
            PH_RUN_A:  return PH_SWAP;
            PH_SWAP:   return PH_RUN_B;
            PH_RUN_B:  return PH_DRAIN;
            PH_DRAIN:  return PH_DONE;
            default:   return ph;
        endcase
    endfunction

    function automatic mode_pair_t modes_for(phase_e ph);
        mode_pair_t m;
        case (ph)
            PH_LOAD_A: begin m.a = MD_SHIFT; m.b = MD_CLEAR; end
            PH_RUN_A:  begin m.a = MD_SIG;   m.b = MD_SIG;   end
            PH_SWAP:   begin m.a = MD_CLEAR; m.b = MD_SHIFT; end
            PH_RUN_B:  begin m.a = MD_SIG;   m.b = MD_SIG;   end
            PH_DRAIN:  begin m.a = MD_SHIFT; m.b = MD_NORM;  end
            default:   begin m.a = MD_NORM;  m.b = MD_NORM;  end
        endcase
        return m;
    endfunction

endpackage

// File: rtl/bist_seq_ctrl.sv
module bist_seq_ctrl
    import bist_seq_pkg::*;
#(
    parameter int W     = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [CNT_W-1:0] run_cycles_i,
    output phase_e           phase_o,
    output logic [CNT_W-1:0] step_o,
    output logic             last_o,
    output logic             accept_o
);
    localparam logic [CNT_W-1:0] SCAN_LEN = CNT_W'(W);

    phase_e           phase_q;
    logic [CNT_W-1:0] step_q;
    logic [CNT_W-1:0] run_len_q;
    logic [CNT_W-1:0] cur_len;

    always_comb begin
        cur_len  = is_scan(phase_q) ? SCAN_LEN : run_len_q;
        last_o   = is_busy(phase_q) && (step_q == cur_len - CNT_W'(1));
        accept_o = start_i && !is_busy(phase_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            step_q    <= '0;
            run_len_q <= CNT_W'(1);
        end else if (accept_o) begin
            phase_q   <= PH_LOAD_A;
            step_q    <= '0;
            run_len_q <= (run_cycles_i == '0) ? CNT_W'(1) : run_cycles_i;
        end else if (last_o) begin
            phase_q <= next_phase(phase_q);
            step_q  <= '0;
        end else if (is_busy(phase_q)) begin
            step_q <= step_q + CNT_W'(1);
        end
    end

    assign phase_o = phase_q;
    assign step_o  = step_q;
endmodule

// File: rtl/bist_scan_drv.sv
module bist_scan_drv
    import bist_seq_pkg::*;
#(
    parameter int          W      = 8,
    parameter int          CNT_W  = 16,
    parameter logic [W-1:0] SEED_A = 8'h81,
    parameter logic [W-1:0] SEED_B = 8'h3C
) (
    input  phase_e           phase_i,
    input  logic [CNT_W-1:0] step_i,
    output logic             scan_in_a_o,
    output logic             scan_in_b_o
);
    localparam int IW = (W > 1) ? $clog2(W) : 1;

    logic [IW-1:0] pos;

    always_comb begin
        pos         = IW'(W - 1) - step_i[IW-1:0];
        scan_in_a_o = (phase_i == PH_LOAD_A) ? SEED_A[pos] : 1'b0;
        scan_in_b_o = (phase_i == PH_SWAP)   ? SEED_B[pos] : 1'b0;
    end
endmodule

// File: rtl/bist_sig_lane.sv
module bist_sig_lane #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear_i,
    input  logic [W-1:0] exp_i,
    input  logic         active_i,
    input  logic         last_i,
    input  logic         sbit_i,
    output logic         mismatch_o
);
    logic [W-1:0] exp_q;
    logic [W-1:0] cap_q;
    logic [W-1:0] word;

    always_comb begin
        word       = {cap_q[W-2:0], sbit_i};
        mismatch_o = active_i && last_i && (word != exp_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_q <= '0;
            cap_q <= '0;
        end else if (clear_i) begin
            exp_q <= exp_i;
            cap_q <= '0;
        end else if (active_i) begin
            cap_q <= word;
        end
    end
endmodule

// File: rtl/bist_pingpong_seq.sv
module bist_pingpong_seq
    import bist_seq_pkg::*;
#(
    parameter int           W      = 8,
    parameter int           CNT_W  = 16,
    parameter logic [W-1:0] SEED_A = 8'h81,
    parameter logic [W-1:0] SEED_B = 8'h3C
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [CNT_W-1:0] run_cycles_i,
    input  logic [W-1:0]     exp_sig_a_i,
    input  logic [W-1:0]     exp_sig_b_i,
    input  logic             scan_out_a_i,
    input  logic             scan_out_b_i,
    output logic             scan_in_a_o,
    output logic             scan_in_b_o,
    output logic [1:0]       mode_a_o,
    output logic [1:0]       mode_b_o,
    output logic             done_o,
    output logic             fail_o
);
    localparam int LANES = 2;

    phase_e           phase;
    logic [CNT_W-1:0] step;
    logic             last;
    logic             accept;
    logic [LANES-1:0] mism;
    logic             fail_q;
    mode_pair_t       mp;

    bist_seq_ctrl #(.W(W), .CNT_W(CNT_W)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .run_cycles_i (run_cycles_i),
        .phase_o      (phase),
        .step_o       (step),
        .last_o       (last),
        .accept_o     (accept)
    );

    bist_scan_drv #(.W(W), .CNT_W(CNT_W), .SEED_A(SEED_A), .SEED_B(SEED_B)) u_drv (
        .phase_i     (phase),
        .step_i      (step),
        .scan_in_a_o (scan_in_a_o),
        .scan_in_b_o (scan_in_b_o)
    );

    // lane 0 reads register B during the swap, lane 1 reads register A during the drain
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        bist_sig_lane #(.W(W)) u_lane (
            .clk        (clk),
            .rst        (rst),
            .clear_i    (accept),
            .exp_i      ((g == 0) ? exp_sig_a_i : exp_sig_b_i),
            .active_i   (phase == ((g == 0) ? PH_SWAP : PH_DRAIN)),
            .last_i     (last),
            .sbit_i     ((g == 0) ? scan_out_b_i : scan_out_a_i),
            .mismatch_o (mism[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)         fail_q <= 1'b0;
        else if (accept) fail_q <= 1'b0;
        else if (|mism)  fail_q <= 1'b1;
    end

    always_comb begin
        mp       = modes_for(phase);
        mode_a_o = mp.a;
        mode_b_o = mp.b;
        done_o   = (phase == PH_DONE);
        fail_o   = fail_q;
    end
endmodule

// File: rtl/bist_pingpong_chk.sv
module bist_pingpong_chk (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic [1:0] mode_a_o,
    input logic [1:0] mode_b_o,
    input logic       done_o,
    input logic       fail_o
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (mode_a_o == 2'b11 && mode_b_o == 2'b11 && !done_o && !fail_o));

    // R2
    clear_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_b_o == 2'b01) |-> (mode_a_o == 2'b00));

    // R3
    sig_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_a_o == 2'b10) |-> (mode_b_o == 2'b10));

    // R4
    one_shifter_chk: assert property (@(posedge clk) disable iff (rst)
        !(mode_a_o == 2'b00 && mode_b_o == 2'b00));

    // R7
    fail_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(fail_o) |-> $past(start_i));

    // R8
    done_normal_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (mode_a_o == 2'b11 && mode_b_o == 2'b11));

    // R6
    done_after_drain_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> ($past(mode_a_o) == 2'b00 && $past(mode_b_o) == 2'b11));
endmodule

bind bist_pingpong_seq bist_pingpong_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .mode_a_o (mode_a_o),
    .mode_b_o (mode_b_o),
    .done_o   (done_o),
    .fail_o   (fail_o)
);

// File: tb/sim_bist_pingpong_seq.sv
`timescale 1ns/1ps
module sim_bist_pingpong_seq;
    localparam int           W      = 8;
    localparam int           CNT_W  = 16;
    localparam logic [W-1:0] SEED_A = 8'h81;
    localparam logic [W-1:0] SEED_B = 8'h3C;
    localparam logic [W-1:0] TAPS   = 8'hB8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [CNT_W-1:0] run_cycles_i = '0;
    logic [W-1:0]     exp_sig_a_i = '0;
    logic [W-1:0]     exp_sig_b_i = '0;
    logic             scan_out_a_i, scan_out_b_i;
    logic             scan_in_a_o, scan_in_b_o;
    logic [1:0]       mode_a_o, mode_b_o;
    logic             done_o, fail_o;

    always #5 clk = ~clk;

    bist_pingpong_seq #(.W(W), .CNT_W(CNT_W), .SEED_A(SEED_A), .SEED_B(SEED_B)) u0 (.*);

    // behavioural test registers and networks
    function automatic logic [W-1:0] lstep(logic [W-1:0] q, logic [W-1:0] d);
        return {q[W-2:0], ^(q & TAPS)} ^ d;
    endfunction
    function automatic logic [W-1:0] net1(logic [W-1:0] x);
        return {x[2:0], x[7:3]} ^ 8'h5A;
    endfunction
    function automatic logic [W-1:0] net2(logic [W-1:0] x);
        return ~{x[0], x[7:1]} ^ 8'h21;
    endfunction

    logic [W-1:0] reg_a, reg_b;
    assign scan_out_a_i = reg_a[W-1];
    assign scan_out_b_i = reg_b[W-1];

    always @(posedge clk) begin
        if (rst) begin
            reg_a <= '0;
            reg_b <= '0;
        end else begin
            case (mode_a_o)
                2'b11: reg_a <= net2(reg_b);
                2'b00: reg_a <= {reg_a[W-2:0], scan_in_a_o};
                2'b10: reg_a <= lstep(reg_a, net2(reg_b));
                default: reg_a <= '0;
            endcase
            case (mode_b_o)
                2'b11: reg_b <= net1(reg_a);
                2'b00: reg_b <= {reg_b[W-2:0], scan_in_b_o};
                2'b10: reg_b <= lstep(reg_b, net1(reg_a));
                default: reg_b <= '0;
            endcase
        end
    end

    // golden signatures from a closed-form run of the ring
    task automatic golden(input int n, output logic [W-1:0] ga, output logic [W-1:0] gb);
        logic [W-1:0] a, b, na, nb;
        a = SEED_A; b = '0;
        for (int i = 0; i < n; i++) begin
            na = lstep(a, net2(b)); nb = lstep(b, net1(a)); a = na; b = nb;
        end
        ga = b;
        a = '0; b = SEED_B;
        for (int i = 0; i < n; i++) begin
            na = lstep(a, net2(b)); nb = lstep(b, net1(a)); a = na; b = nb;
        end
        gb = a;
    endtask

    // reference model of the schedule
    int           checks = 0, fails = 0;
    bit           chk_on = 0;
    bit           m_busy = 0, m_done = 0, m_fail = 0;
    int           m_t = 0, m_n = 1;
    logic [W-1:0] m_exa, m_exb, m_ga, m_gb;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; m_fail = 0;
        end else if (m_busy) begin
            m_t = m_t + 1;
            if (m_t == 2*W + m_n) m_fail = m_fail | (m_ga != m_exa);
            if (m_t == 3*W + 2*m_n) begin
                m_fail = m_fail | (m_gb != m_exb);
                m_busy = 0; m_done = 1;
            end
        end else if (start_i) begin
            m_busy = 1; m_t = 0; m_done = 0; m_fail = 0;
            m_n = (run_cycles_i == 0) ? 1 : int'(run_cycles_i);
            m_exa = exp_sig_a_i; m_exb = exp_sig_b_i;
            golden(m_n, m_ga, m_gb);
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on) begin
            logic [1:0] ea, eb;
            logic       sa, sb;
            string      tag;
            ea = 2'b11; eb = 2'b11; sa = 1'b0; sb = 1'b0;
            tag = m_done ? "R8" : "R1";
            if (m_busy) begin
                if (m_t < W) begin
                    ea = 2'b00; eb = 2'b01; sa = SEED_A[W-1-m_t]; tag = "R2";
                end else if (m_t < W + m_n) begin
                    ea = 2'b10; eb = 2'b10; tag = "R3";
                end else if (m_t < 2*W + m_n) begin
                    ea = 2'b01; eb = 2'b00; sb = SEED_B[W-1-(m_t-W-m_n)]; tag = "R4";
                end else if (m_t < 2*W + 2*m_n) begin
                    ea = 2'b10; eb = 2'b10; tag = "R5";
                end else begin
                    ea = 2'b00; eb = 2'b11; tag = "R6";
                end
            end
            chk(mode_a_o == ea, tag, "mode_a", mode_a_o, ea);
            chk(mode_b_o == eb, tag, "mode_b", mode_b_o, eb);
            chk(scan_in_a_o == sa, tag, "scan_in_a", scan_in_a_o, sa);
            chk(scan_in_b_o == sb, tag, "scan_in_b", scan_in_b_o, sb);
            chk(done_o == m_done, "R8", "done", done_o, m_done);
            chk(fail_o == m_fail, "R7", "fail", fail_o, m_fail);
        end
    end

    task automatic launch(input int n, input logic [W-1:0] ea, input logic [W-1:0] eb);
        @(negedge clk);
        run_cycles_i = CNT_W'(n); exp_sig_a_i = ea; exp_sig_b_i = eb; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done(input string tag, input bit exp_fail);
        bit seen = 0;
        for (int i = 0; i < 2000; i++) begin
            if (done_o) begin seen = 1; break; end
            @(negedge clk);
        end
        chk(seen, tag, "done reached", seen, 1);
        chk(fail_o == exp_fail, tag, "final fail", fail_o, exp_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [W-1:0] ga, gb;
        repeat (3) @(posedge clk);
        chk_on = 1;
        @(negedge clk);
        // R1 reset state
        chk(mode_a_o == 2'b11 && mode_b_o == 2'b11 && !done_o && !fail_o,
            "R1", "reset state", {mode_a_o, mode_b_o, done_o, fail_o}, 6'h3C);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // correct signatures, R2 R3 R4 R5 R6 through the per-cycle model
        golden(5, ga, gb);
        launch(5, ga, gb);
        wait_done("R7", 1'b0);

        // wrong first expected word
        golden(3, ga, gb);
        launch(3, ga ^ 8'h01, gb);
        wait_done("R7", 1'b1);

        // restart clears fail and done; wrong second word only
        golden(4, ga, gb);
        launch(4, ga, gb ^ 8'h80);
        chk(!done_o && !fail_o, "R8", "cleared by start", {done_o, fail_o}, 0);
        wait_done("R7", 1'b1);

        // zero run count behaves as one
        golden(1, ga, gb);
        launch(0, ga, gb);
        wait_done("R3", 1'b0);

        // mid-run starts and input changes are ignored
        golden(6, ga, gb);
        launch(6, ga, gb);
        repeat (3) @(negedge clk);
        start_i = 1'b1; run_cycles_i = 16'd2; exp_sig_a_i = ~ga; exp_sig_b_i = ~gb;
        @(negedge clk);
        start_i = 1'b0;
        repeat (12) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done("R9", 1'b0);
        chk(fail_o == 1'b0, "R10", "latched inputs kept", fail_o, 0);

        repeat (3) @(negedge clk);
        chk(done_o && mode_a_o == 2'b11 && mode_b_o == 2'b11, "R8", "done holds",
            {done_o, mode_a_o, mode_b_o}, 5'h1F);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule